// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Permissions

This block holds a small number of recent virtual-to-physical page translations. Each stored slot carries the whole page table entry, that is the physical page number together with its access permission bits. A lookup is presented with a virtual page number. One cycle later the block reports hit or miss, and on a hit it also reports the physical page number and the permission bits. No memory access is needed for any of this.

When a lookup misses, an external page-table walker fetches the entry and writes it in through the refill port. Later lookups of that page then hit. A flush input drops every stored translation in a single cycle, which is what a context switch needs. The virtual page number is divided into two fields. Its lowest bits choose one of the sets, and the remaining upper bits form the tag. The tag is compared against every way of the chosen set. The default build has 4 sets of 4 ways, which gives 16 entries. SETS and WAYS must be powers of two, and SETS must be at least 2.

Top module: `tlb_xlate`

## Requirements
- R1: `rsp_valid` is high in the cycle right after a cycle with `lk_en` high, and low in the cycle after a cycle with `lk_en` low. `rsp_hit` is never high while `rsp_valid` is low.
- R2: The set index is `lk_vpn[IDX_W-1:0]` (IDX_W = log2 SETS) and the tag is the remaining upper bits. A lookup hits only when a way of that set is valid and holds that tag. On a hit, `rsp_ppn` and `rsp_perm` are the values stored by the refill that installed the way.
- R3: On a miss, `rsp_ppn` and `rsp_perm` are both zero.
- R4: A refill (`rf_en` high, `flush` low) installs its entry, so lookups of that VPN in later cycles hit. A lookup in the same cycle as the refill still sees the contents from before the refill.
- R5: A refill of a VPN that is not present goes to the lowest-numbered invalid way of its set, if that set has one.
- R6: If every way of the set is valid, the refill replaces the way chosen by that set's round-robin pointer. The pointer is 0 after reset. It advances by one, wrapping, only when it is used to choose a victim. Flush does not change it.
- R7: A refill of a VPN that is already present overwrites that same way. It creates no duplicate, evicts nothing and leaves the pointer unchanged.
- R8: `flush` clears every valid bit in one cycle. A lookup in the same cycle as `flush` reports a miss.
- R9: When `rf_en` and `flush` are high in the same cycle, the flush wins and the refill is discarded.
- R10: After reset every way is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_en | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rf_en | input | 1 | Refill write strobe from the walker |
| rf_vpn | input | VPN_W | Virtual page number being installed |
| rf_ppn | input | PPN_W | Physical page number being installed |
| rf_perm | input | PERM_W | Permission bits being installed, stored as given |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup result is present this cycle |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_ppn | output | PPN_W | Translated physical page number, zero on miss |
| rsp_perm | output | PERM_W | Permission bits of the translation, zero on miss |

## Verification
The tests start with directed sequences, and each one isolates a single behaviour:
- Four VPNs sharing one set index fill it. This separates invalid-first placement from round-robin eviction.
- Fifth and sixth refills show which way each one evicts.
- A rewrite of a resident VPN tells an in-place overwrite apart from a duplicate allocation.
- Refills in a neighbouring set show that sets are independent.
- The same-cycle cases cover lookup with refill, lookup with flush, and refill with flush. They tell apart which state a lookup observes and which input takes priority.

After these, an LFSR-driven run mixes lookups, refills and rare flushes over a 32-VPN pool against a reference model. This exposes ordering errors that the directed cases miss.

// File: rtl/tlb_pkg.sv
// Package: shared default geometry for the translation cache.
// Assumes: SETS and WAYS are powers of two, SETS >= 2.
package tlb_pkg;
    localparam int DEF_VPN_W  = 20;
    localparam int DEF_PPN_W  = 16;
    localparam int DEF_PERM_W = 3;
    localparam int DEF_SETS   = 4;
    localparam int DEF_WAYS   = 4;
endpackage

// File: rtl/tlb_way_array.sv
// Module: entry storage for all sets and ways.
// It provides one write port, one full read port (used by lookup) and one
// tag/valid read port (used by refill). Valid bits are cleared by reset or
// by flush. Tag and data registers are not reset.
// Assumes: the caller gates wr_en with flush, and SETS >= 2.
module tlb_way_array #(
    parameter int SETS   = tlb_pkg::DEF_SETS,
    parameter int WAYS   = tlb_pkg::DEF_WAYS,
    parameter int TAG_W  = 18,
    parameter int DATA_W = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  wr_set,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(SETS)-1:0]  ra_set,
    output logic [WAYS-1:0]          ra_valid,
    output logic [WAYS*TAG_W-1:0]    ra_tags,
    output logic [WAYS*DATA_W-1:0]   ra_data,
    input  logic [$clog2(SETS)-1:0]  rb_set,
    output logic [WAYS-1:0]          rb_valid,
    output logic [WAYS*TAG_W-1:0]    rb_tags
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int SLOTS = SETS * WAYS;

    logic [SLOTS-1:0]        valid_q;
    logic [SLOTS*TAG_W-1:0]  tag_q;
    logic [SLOTS*DATA_W-1:0] data_q;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            localparam logic [IDX_W-1:0] S_ID = IDX_W'(s);
            localparam logic [WAY_W-1:0] W_ID = WAY_W'(w);
            localparam int               SLOT = s * WAYS + w;
            logic sel;
            assign sel = wr_en && (wr_set == S_ID) && (wr_way == W_ID);

            // Valid bit: cleared by reset or flush, set by a write to this slot.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) valid_q[SLOT] <= 1'b0;
                else if (sel)        valid_q[SLOT] <= 1'b1;
            end

            // Tag and payload: loaded on a write to this slot.
            always_ff @(posedge clk) begin
                if (sel) begin
                    tag_q[SLOT*TAG_W +: TAG_W]    <= wr_tag;
                    data_q[SLOT*DATA_W +: DATA_W] <= wr_data;
                end
            end
        end
    end

    // Read ports: slice out the selected set.
    always_comb begin
        ra_valid = valid_q[ra_set*WAYS +: WAYS];
        ra_tags  = tag_q[ra_set*WAYS*TAG_W +: WAYS*TAG_W];
        ra_data  = data_q[ra_set*WAYS*DATA_W +: WAYS*DATA_W];
        rb_valid = valid_q[rb_set*WAYS +: WAYS];
        rb_tags  = tag_q[rb_set*WAYS*TAG_W +: WAYS*TAG_W];
    end
endmodule

// File: rtl/tlb_tag_cmp.sv
// Module: compares a tag against every way of one set.
// It produces a per-way match vector and the index of the lowest match.
// Assumes: at most one way matches, which the refill policy guarantees.
module tlb_tag_cmp #(
    parameter int WAYS  = tlb_pkg::DEF_WAYS,
    parameter int TAG_W = 18
) (
    input  logic [WAYS-1:0]         valid,
    input  logic [WAYS*TAG_W-1:0]   tags,
    input  logic [TAG_W-1:0]        tag,
    output logic [WAYS-1:0]         hit_vec,
    output logic [$clog2(WAYS)-1:0] hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    // Per-way match: the way must be valid and its tag must be equal.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
    end

    // Encode the lowest matching way.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Module: chooses the way a new entry is written to.
// It picks the lowest invalid way if there is one, otherwise the set's
// round-robin pointer. The pointer advances only when it is actually used.
// Assumes: WAYS is a power of two, so the pointer wraps naturally.
module tlb_victim #(
    parameter int SETS = tlb_pkg::DEF_SETS,
    parameter int WAYS = tlb_pkg::DEF_WAYS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] set,
    input  logic [WAYS-1:0]         way_valid,
    input  logic                    alloc,
    output logic [$clog2(WAYS)-1:0] pick
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] rr_q [SETS];
    logic             full;
    logic [WAY_W-1:0] free_way;

    // Lowest invalid way of the addressed set.
    always_comb begin
        full     = &way_valid;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) free_way = WAY_W'(w);
        end
    end

    assign pick = full ? rr_q[set] : free_way;

    for (genvar s = 0; s < SETS; s++) begin : g_rr
        localparam logic [IDX_W-1:0] S_ID = IDX_W'(s);
        // Round-robin pointer: steps when a full set loses a way.
        always_ff @(posedge clk) begin
            if (!rst_n)                             rr_q[s] <= '0;
            else if (alloc && full && set == S_ID)  rr_q[s] <= rr_q[s] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
// Module: set-associative translation cache holding PPN plus permissions.
// A lookup gives a registered response one cycle later. A refill writes a
// full entry, reusing the way if the VPN is already present. Flush
// invalidates everything and takes priority over a refill in the same cycle.
// Assumes: SETS and WAYS are powers of two, SETS >= 2.
module tlb_xlate #(
    parameter int VPN_W  = tlb_pkg::DEF_VPN_W,
    parameter int PPN_W  = tlb_pkg::DEF_PPN_W,
    parameter int PERM_W = tlb_pkg::DEF_PERM_W,
    parameter int SETS   = tlb_pkg::DEF_SETS,
    parameter int WAYS   = tlb_pkg::DEF_WAYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic [PERM_W-1:0] rf_perm,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = VPN_W - IDX_W;
    localparam int DATA_W = PPN_W + PERM_W;

    logic [IDX_W-1:0]       lk_set, rf_set;
    logic [TAG_W-1:0]       lk_tag, rf_tag;
    logic [WAYS-1:0]        lk_valid, rf_valid;
    logic [WAYS*TAG_W-1:0]  lk_tags, rf_tags;
    logic [WAYS*DATA_W-1:0] lk_data;
    logic [WAYS-1:0]        lk_hit_vec, rf_hit_vec;
    logic [WAY_W-1:0]       lk_hit_way, rf_hit_way, vic_way;
    logic                   lk_hit, rf_present, wr_en, alloc;
    logic [DATA_W-1:0]      lk_entry;

    assign lk_set = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign rf_set = rf_vpn[IDX_W-1:0];
    assign rf_tag = rf_vpn[VPN_W-1:IDX_W];

    tlb_way_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_set   (rf_set),
        .wr_way   (rf_present ? rf_hit_way : vic_way),
        .wr_tag   (rf_tag),
        .wr_data  ({rf_ppn, rf_perm}),
        .ra_set   (lk_set),
        .ra_valid (lk_valid),
        .ra_tags  (lk_tags),
        .ra_data  (lk_data),
        .rb_set   (rf_set),
        .rb_valid (rf_valid),
        .rb_tags  (rf_tags)
    );

    tlb_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
        .valid   (lk_valid),
        .tags    (lk_tags),
        .tag     (lk_tag),
        .hit_vec (lk_hit_vec),
        .hit_way (lk_hit_way)
    );

    tlb_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rf_cmp (
        .valid   (rf_valid),
        .tags    (rf_tags),
        .tag     (rf_tag),
        .hit_vec (rf_hit_vec),
        .hit_way (rf_hit_way)
    );

    tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (rf_set),
        .way_valid (rf_valid),
        .alloc     (alloc),
        .pick      (vic_way)
    );

    // Refill control: flush wins, and a present VPN is rewritten in place.
    always_comb begin
        rf_present = |rf_hit_vec;
        wr_en      = rf_en && !flush;
        alloc      = wr_en && !rf_present;
        lk_hit     = |lk_hit_vec;
        lk_entry   = lk_data[lk_hit_way*DATA_W +: DATA_W];
    end

    // Response register: result one cycle after the lookup, zeroed on miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_en;
            rsp_hit   <= lk_en && lk_hit && !flush;
            if (lk_en && lk_hit && !flush) begin
                {rsp_ppn, rsp_perm} <= lk_entry;
            end else begin
                rsp_ppn  <= '0;
                rsp_perm <= '0;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
// Module: property checker for tlb_xlate, attached with bind below.
// Assumes: it is bound into every tlb_xlate instance.
module tlb_xlate_chk #(
    parameter int PPN_W  = 16,
    parameter int PERM_W = 3,
    parameter int WAYS   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_en,
    input logic              flush,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PPN_W-1:0]  rsp_ppn,
    input logic [PERM_W-1:0] rsp_perm,
    input logic [WAYS-1:0]   lk_hit_vec
);
    p_rsp_after_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> rsp_valid);
    p_no_rsp_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> !rsp_valid);
    p_hit_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);
    p_miss_is_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0));
    p_flush_lookup_misses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && flush) |=> !rsp_hit);
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));
endmodule

bind tlb_xlate tlb_xlate_chk #(.PPN_W(PPN_W), .PERM_W(PERM_W), .WAYS(WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_en      (lk_en),
    .flush      (flush),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_ppn    (rsp_ppn),
    .rsp_perm   (rsp_perm),
    .lk_hit_vec (lk_hit_vec)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
// Bench: the driver applies one cycle of stimulus and pushes the expected
// response into a queue. The monitor pops one item per cycle and compares.
module sim_tlb_xlate;
    localparam int VPN_W = 20, PPN_W = 16, PERM_W = 3, SETS = 4, WAYS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_en = 1'b0, rf_en = 1'b0, flush = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0, rf_vpn = '0;
    logic [PPN_W-1:0]  rf_ppn = '0;
    logic [PERM_W-1:0] rf_perm = '0;
    logic              rsp_valid, rsp_hit;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [PERM_W-1:0] rsp_perm;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic              v;
        logic              h;
        logic [PPN_W-1:0]  p;
        logic [PERM_W-1:0] m;
        string             req;
    } exp_t;
    exp_t q[$];

    // Reference model state
    bit                m_val [SETS][WAYS];
    logic [VPN_W-1:0]  m_vpn [SETS][WAYS];
    logic [PPN_W-1:0]  m_ppn [SETS][WAYS];
    logic [PERM_W-1:0] m_prm [SETS][WAYS];
    int                m_rr  [SETS];

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_perm(rf_perm),
        .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
    );

    always #10 clk = ~clk;

    task automatic step(input bit lk, input int lv, input bit rf, input int rv,
                        input int rp, input int rm, input bit fl, input string req);
        exp_t e;
        int   s, hw, fw;
        @(negedge clk);
        lk_en = lk; lk_vpn = VPN_W'(lv); rf_en = rf; rf_vpn = VPN_W'(rv);
        rf_ppn = PPN_W'(rp); rf_perm = PERM_W'(rm); flush = fl;
        // expected response from the state before this cycle
        e.v = lk; e.h = 0; e.p = '0; e.m = '0; e.req = lk ? req : "R1";
        s = lv % SETS;
        if (lk && !fl) begin
            for (int w = 0; w < WAYS; w++) begin
                if (m_val[s][w] && m_vpn[s][w] == VPN_W'(lv)) begin
                    e.h = 1; e.p = m_ppn[s][w]; e.m = m_prm[s][w];
                end
            end
        end
        q.push_back(e);
        // model update
        if (fl) begin
            for (int a = 0; a < SETS; a++)
                for (int w = 0; w < WAYS; w++) m_val[a][w] = 0;
        end else if (rf) begin
            s = rv % SETS; hw = -1; fw = -1;
            for (int w = 0; w < WAYS; w++)
                if (m_val[s][w] && m_vpn[s][w] == VPN_W'(rv)) hw = w;
            for (int w = WAYS - 1; w >= 0; w--)
                if (!m_val[s][w]) fw = w;
            if (hw < 0) begin
                if (fw >= 0) hw = fw;
                else begin hw = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % WAYS; end
            end
            m_val[s][hw] = 1; m_vpn[s][hw] = VPN_W'(rv);
            m_ppn[s][hw] = PPN_W'(rp); m_prm[s][hw] = PERM_W'(rm);
        end
    endtask

    task automatic look(input int v, input string req);
        step(1, v, 0, 0, 0, 0, 0, req);
    endtask
    task automatic fill(input int v, input int p, input int m, input string req);
        step(0, 0, 1, v, p, m, 0, req);
    endtask

    // Monitor: samples 5 ns after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                if (rsp_valid !== e.v || rsp_hit !== e.h ||
                    rsp_ppn !== e.p || rsp_perm !== e.m) begin
                    n_bad++;
                    $display("FAIL %s: got v=%b h=%b ppn=%h perm=%h, want v=%b h=%b ppn=%h perm=%h",
                             e.req, rsp_valid, rsp_hit, rsp_ppn, rsp_perm,
                             e.v, e.h, e.p, e.m);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int a = 0; a < SETS; a++) begin
            m_rr[a] = 0;
            for (int w = 0; w < WAYS; w++) m_val[a][w] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: got rsp_valid=%b, want 0", rsp_valid);
        end
        look(32'h10, "R10");                 // empty after reset
        step(0, 0, 0, 0, 0, 0, 0, "R1");     // idle cycle
        // R4: install, then hit
        fill(32'h10, 16'h1111, 3'b101, "R4");
        look(32'h10, "R4");
        look(32'h11, "R2");                  // same tag, other set: miss
        // R5: fill remaining ways of set 0
        fill(32'h20, 16'h2222, 3'b001, "R5");
        fill(32'h30, 16'h3333, 3'b010, "R5");
        fill(32'h40, 16'h4444, 3'b011, "R5");
        look(32'h20, "R5"); look(32'h30, "R5"); look(32'h40, "R5"); look(32'h10, "R5");
        // R7: rewrite a present entry in place
        fill(32'h30, 16'h3A3A, 3'b111, "R7");
        look(32'h30, "R7"); look(32'h10, "R7"); look(32'h20, "R7"); look(32'h40, "R7");
        // R6: set full, victims are way 0 then way 1
        fill(32'h50, 16'h5555, 3'b100, "R6");
        look(32'h10, "R6"); look(32'h50, "R6"); look(32'h20, "R6");
        fill(32'h60, 16'h6666, 3'b110, "R6");
        look(32'h20, "R6"); look(32'h60, "R6"); look(32'h30, "R6"); look(32'h40, "R6");
        // R2: another set is independent
        fill(32'h11, 16'h0B0B, 3'b010, "R2");
        look(32'h11, "R2"); look(32'h50, "R2");
        // R4: lookup and refill in the same cycle
        step(1, 32'h71, 1, 32'h71, 16'h7777, 3'b001, 0, "R4");
        look(32'h71, "R4");
        // R8: flush with lookup, then everything misses
        step(1, 32'h50, 0, 0, 0, 0, 1, "R8");
        look(32'h60, "R8"); look(32'h11, "R8");
        // R9: refill and flush together
        step(0, 0, 1, 32'h82, 16'h8888, 3'b111, 1, "R9");
        look(32'h82, "R9");
        // R6: pointer kept across flush; refill set 0 until full and evict
        fill(32'h10, 16'h0101, 3'b001, "R5");
        fill(32'h20, 16'h0202, 3'b001, "R5");
        fill(32'h30, 16'h0303, 3'b001, "R5");
        fill(32'h40, 16'h0404, 3'b001, "R5");
        fill(32'h90, 16'h0909, 3'b010, "R6");
        look(32'h30, "R6"); look(32'h90, "R6"); look(32'h10, "R6"); look(32'h40, "R6");
        // Mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], {27'd0, lfsr[5:1]}, lfsr[6], {27'd0, lfsr[11:7]},
                 {16'd0, lfsr}, {29'd0, lfsr[14:12]},
                 (lfsr[15:12] == 4'hF) && lfsr[0], "R2");
        end
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule